// File: doc/BRIEF.md
# Twenty-Two Function 8-Bit ALU

This block is a purely combinational arithmetic logic unit for two 8-bit operands. A 5-bit operation code selects one of twenty-two functions. The functions cover operand pass-through, bitwise logic, two constants, increment, decrement and two's-complement negation of either operand, and addition and subtraction with or without a carry or borrow input. A reverse subtraction is also provided. The block returns an 8-bit result and a single carry flag. The flag has a fixed meaning for each function.

The flag is a carry for additions, increments and negation. It is a borrow for subtractions and decrements. The carry input affects only the two "with carry" operations, so a caller can leave it at any level for every other function. Every arithmetic function is computed by one shared adder, which sits behind an operand-conditioning stage. Codes above 21 produce zero outputs.

Top module: `alu22`

## Requirements
- R1: Codes 0 to 8 give, in order, A, B, NOT A, NOT B, A XOR B, A OR B, A AND B, A NAND B and A XNOR B on the result.
- R2: For codes 0 to 10, carry_o is 0.
- R3: Code 9 gives 0x00 and code 10 gives 0xFF, whatever the operands.
- R4: Codes 11 and 12 give A+1 and B+1. carry_o is 1 only when the operand was 0xFF, in which case the result is 0x00.
- R5: Codes 13 and 14 give A-1 and B-1. carry_o is 1 only when the operand was 0x00, in which case the result is 0xFF.
- R6: Codes 15 and 16 give the two's complement of A and of B. carry_o is 1 only when the operand is 0x00.
- R7: Code 17 gives A+B and code 18 gives A+B+carry_i. In both cases carry_o is the carry out of bit 7.
- R8: Code 19 gives A-B and code 20 gives A-B-carry_i. carry_o is 1 when the true difference is negative, acting as a borrow.
- R9: Code 21 gives B-A. carry_o is 1 when A is greater than B.
- R10: carry_i has no effect on either output for any code other than 18 and 20.
- R11: Codes 22 to 31 give a result of 0x00 and carry_o of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| carry_i | input | 1 | Carry or borrow input, used by codes 18 and 20 |
| op_i | input | 5 | Operation code |
| result_o | output | 8 | Operation result |
| carry_o | output | 1 | Carry or borrow flag |

## Verification
Two meanings of the flag meet in the same evaluation. The shared adder's raw carry must be inverted into a borrow for codes 13, 14 and 19 to 21, but not for codes 11, 12 and 15 to 18. At the same time, carry_i feeds the adder for codes 18 and 20 only. The bench stresses this by applying every arithmetic code at the operand extremes 0x00 and 0xFF with carry_i at both levels. It then repeats each random vector with carry_i flipped. Each result is compared with a reference built from wide integer arithmetic and an explicit comparison for the borrow, and each code other than 18 and 20 is required to return identical outputs in both runs.

// File: rtl/alu22_pkg.sv
package alu22_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_PASS_A  = 5'd0,  OP_PASS_B  = 5'd1,  OP_NOT_A   = 5'd2,
    OP_NOT_B   = 5'd3,  OP_XOR     = 5'd4,  OP_OR      = 5'd5,
    OP_AND     = 5'd6,  OP_NAND    = 5'd7,  OP_XNOR    = 5'd8,
    OP_ZERO    = 5'd9,  OP_ONES    = 5'd10, OP_INC_A   = 5'd11,
    OP_INC_B   = 5'd12, OP_DEC_A   = 5'd13, OP_DEC_B   = 5'd14,
    OP_NEG_A   = 5'd15, OP_NEG_B   = 5'd16, OP_ADD     = 5'd17,
    OP_ADD_C   = 5'd18, OP_SUB     = 5'd19, OP_SUB_C   = 5'd20,
    OP_RSUB    = 5'd21
  } op_e;

  localparam int unsigned LAST_LOGIC_OP = 10;
  localparam int unsigned LAST_OP       = 21;
endpackage

// File: rtl/alu22_logic.sv
module alu22_logic
  import alu22_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  op_e              op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_PASS_A: res_o = a_i;
      OP_PASS_B: res_o = b_i;
      OP_NOT_A:  res_o = ~a_i;
      OP_NOT_B:  res_o = ~b_i;
      OP_XOR:    res_o = a_i ^ b_i;
      OP_OR:     res_o = a_i | b_i;
      OP_AND:    res_o = a_i & b_i;
      OP_NAND:   res_o = ~(a_i & b_i);
      OP_XNOR:   res_o = ~(a_i ^ b_i);
      OP_ONES:   res_o = '1;
      default:   res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_ZERO) p_zero_const_r3: assert (res_o == '0);
    if (op_i == OP_ONES) p_ones_const_r3: assert (&res_o);
  end
endmodule

// File: rtl/alu22_arith.sv
module alu22_arith
  import alu22_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  op_e              op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int unsigned SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] x_opnd, y_opnd;
  logic             add_cin, flip_cout;
  logic [SUM_W-1:0] sum_ext;

  // Operand conditioning onto a single adder; borrow ops invert the carry.
  always_comb begin
    x_opnd    = '0;
    y_opnd    = '0;
    add_cin   = 1'b0;
    flip_cout = 1'b0;
    unique case (op_i)
      OP_INC_A: begin x_opnd = a_i;  add_cin = 1'b1; end
      OP_INC_B: begin x_opnd = b_i;  add_cin = 1'b1; end
      OP_DEC_A: begin x_opnd = a_i;  y_opnd = '1; flip_cout = 1'b1; end
      OP_DEC_B: begin x_opnd = b_i;  y_opnd = '1; flip_cout = 1'b1; end
      OP_NEG_A: begin x_opnd = ~a_i; add_cin = 1'b1; end
      OP_NEG_B: begin x_opnd = ~b_i; add_cin = 1'b1; end
      OP_ADD:   begin x_opnd = a_i;  y_opnd = b_i; end
      OP_ADD_C: begin x_opnd = a_i;  y_opnd = b_i; add_cin = cin_i; end
      OP_SUB:   begin x_opnd = a_i;  y_opnd = ~b_i; add_cin = 1'b1;   flip_cout = 1'b1; end
      OP_SUB_C: begin x_opnd = a_i;  y_opnd = ~b_i; add_cin = ~cin_i; flip_cout = 1'b1; end
      OP_RSUB:  begin x_opnd = b_i;  y_opnd = ~a_i; add_cin = 1'b1;   flip_cout = 1'b1; end
      default:  ;
    endcase
  end

  assign sum_ext = {1'b0, x_opnd} + {1'b0, y_opnd} + {{WIDTH{1'b0}}, add_cin};
  assign res_o   = sum_ext[WIDTH-1:0];
  assign cout_o  = sum_ext[WIDTH] ^ flip_cout;

  always_comb begin
    if (op_i == OP_INC_A && cout_o) p_inc_wrap_r4: assert ((res_o == '0) && (&a_i));
    if (op_i == OP_DEC_A && cout_o) p_dec_wrap_r5: assert ((&res_o) && (a_i == '0));
    if (op_i == OP_NEG_B)           p_neg_zero_r6: assert (cout_o == (b_i == '0));
    if (op_i == OP_SUB)             p_sub_borrow_r8: assert (cout_o == (a_i < b_i));
    if (op_i == OP_RSUB)            p_rsub_borrow_r9: assert (cout_o == (b_i < a_i));
  end
endmodule

// File: rtl/alu22.sv
module alu22
  import alu22_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  op_e              op;
  logic [WIDTH-1:0] logic_res, arith_res;
  logic             arith_cout;
  logic             is_logic, is_arith;

  assign op       = op_e'(op_i);
  assign is_logic = (op_i <= OP_W'(LAST_LOGIC_OP));
  assign is_arith = !is_logic && (op_i <= OP_W'(LAST_OP));

  alu22_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i (a_i), .b_i (b_i), .op_i (op), .res_o (logic_res)
  );

  alu22_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i (a_i), .b_i (b_i), .cin_i (carry_i), .op_i (op),
    .res_o (arith_res), .cout_o (arith_cout)
  );

  always_comb begin
    result_o = '0;
    carry_o  = 1'b0;
    if (is_logic) begin
      result_o = logic_res;
    end else if (is_arith) begin
      result_o = arith_res;
      carry_o  = arith_cout;
    end
  end

  always_comb begin
    if (is_logic)              p_logic_no_carry_r2: assert (!carry_o);
    if (!is_logic && !is_arith) p_unused_code_r11: assert ((result_o == '0) && !carry_o);
  end
endmodule

// File: tb/alu22_tb.sv
module alu22_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a, b, res;
  logic [4:0] op;
  logic       cin, cout;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  alu22 u_dut (.a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
               .result_o(res), .carry_o(cout));

  function automatic string tag(input int o);
    if (o <= 8)  return "R1";
    if (o <= 10) return "R3";
    if (o <= 12) return "R4";
    if (o <= 14) return "R5";
    if (o <= 16) return "R6";
    if (o <= 18) return "R7";
    if (o <= 20) return "R8";
    if (o == 21) return "R9";
    return "R11";
  endfunction

  // Reference: wide integer arithmetic and explicit comparisons.
  function automatic logic [8:0] model(input int o, input int x, input int y, input int c);
    int r; logic f;
    f = 1'b0; r = 0;
    case (o)
      0: r = x;  1: r = y;  2: r = 255 - x;  3: r = 255 - y;
      4: r = x ^ y;  5: r = x | y;  6: r = x & y;
      7: r = 255 - (x & y);  8: r = 255 - (x ^ y);
      9: r = 0;  10: r = 255;
      11: begin r = x + 1; f = (x == 255); end
      12: begin r = y + 1; f = (y == 255); end
      13: begin r = x - 1; f = (x == 0); end
      14: begin r = y - 1; f = (y == 0); end
      15: begin r = 256 - x; f = (x == 0); end
      16: begin r = 256 - y; f = (y == 0); end
      17: begin r = x + y; f = (r > 255); end
      18: begin r = x + y + c; f = (r > 255); end
      19: begin r = x - y; f = (x < y); end
      20: begin r = x - y - c; f = (x < y + c); end
      21: begin r = y - a_int(x); f = (y < x); end
      default: begin r = 0; f = 1'b0; end
    endcase
    return {f, r[7:0]};
  endfunction

  function automatic int a_int(input int v);
    return v;
  endfunction

  task automatic apply(input int o, input int x, input int y, input int c);
    logic [8:0] exp;
    @(posedge clk);
    op = o[4:0]; a = x[7:0]; b = y[7:0]; cin = c[0];
    @(negedge clk);
    exp = model(o, x, y, c);
    checks++;
    if ({cout, res} !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%0d: got res=%h c=%b exp res=%h c=%b",
               tag(o), o, x[7:0], y[7:0], c, res, cout, exp[7:0], exp[8]);
    end
    if (o <= 10 && cout !== 1'b0) begin
      checks++; failures++;
      $display("FAIL R2 op=%0d carry got %b exp 0", o, cout);
    end
  endtask

  // R10: carry_i flipped must not move the outputs on codes other than 18 and 20
  task automatic cin_blind(input int o, input int x, input int y);
    logic [8:0] first;
    @(posedge clk); op = o[4:0]; a = x[7:0]; b = y[7:0]; cin = 1'b0;
    @(negedge clk); first = {cout, res};
    @(posedge clk); cin = 1'b1;
    @(negedge clk);
    checks++;
    if ({cout, res} !== first) begin
      failures++;
      $display("FAIL R10 op=%0d a=%h b=%h: got %h exp %h", o, x[7:0], y[7:0], {cout, res}, first);
    end
  endtask

  initial begin
    int edges [4] = '{0, 255, 85, 170};
    int seed;
    a = '0; b = '0; cin = 1'b0; op = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (res !== 8'h00 || cout !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset-state res=%h c=%b exp 00 0", res, cout);
    end
    // directed corners from the requirements
    apply(19, 8'h00, 8'hFF, 0);  // R8 borrow
    apply(19, 8'h55, 8'hAA, 0);  // R8
    apply(19, 8'hFF, 8'h00, 0);  // R8 no borrow
    apply(18, 8'hFF, 8'h00, 1);  // R7
    apply(18, 8'hFF, 8'hFF, 1);  // R7
    apply(20, 8'h00, 8'h00, 1);  // R8
    apply(20, 8'hB2, 8'h2B, 1);  // R8
    apply(15, 8'h55, 8'h00, 1);  // R6 with cin held high
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++)
            apply(o, edges[i], edges[j], c);
    seed = 32'h1A2B;
    void'($urandom(seed));
    for (int n = 0; n < 3000; n++) begin
      int o, x, y;
      o = $urandom_range(31, 0);
      x = $urandom_range(255, 0);
      y = $urandom_range(255, 0);
      apply(o, x, y, $urandom_range(1, 0));
      if (o != 18 && o != 20) cin_blind(o, x, y);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule